// File: doc/BRIEF.md
# Serial Configuration Loader Port

This block is a single 16-bit host register through which software loads configuration data, one bit at a time, into programmable logic devices. Software controls three lines by writing register bits: an active-low clear line, a serial clock and a serial data line. The device does not receive a free-running clock. Each configuration clock edge exists only because software wrote a 0 and then a 1 to the clock bit. A read of the same register returns the clock and data bits as written, together with two status flags from the devices: ready and done.

For verification, the block contains a model of the device side. The model comes out of clear one cycle after the clear line is released. It shifts in one data bit on each accepted rising clock edge and counts the bits. It raises done once a parameterised number of bits has arrived. Releasing clear starts a load. The load is complete when the done bit reads back as 1. Driving clear low erases the device and holds it idle.

Top module: `cfg_shift_port`

## Requirements
- R1: After synchronous reset, the clear line is low, the clock and data lines are low, the read word is 0x0000 and the captured word is zero.
- R2: A register write updates the lines on the next clock edge: bit 4 drives the active-low clear line, bit 3 drives the serial clock and bit 2 drives the serial data. The lines hold their values until the next write.
- R3: On a read, bit 3 and bit 2 return the clock and data values last written. Bit 4 reads as 0 because it is write-only. Bits 15 to 5 always read as 0.
- R4: Ready (read bit 1) rises one cycle after the clear line goes high, provided done is not set.
- R5: A data bit is accepted only on a 0-to-1 change of the clock line while ready is high. The accepted bit is the data line value and enters at the LSB of the captured word, which shifts toward the MSB.
- R6: Writing 1 to the clock bit while the clock line is already 1 does not accept another bit.
- R7: Clock edges that occur while the clear line is low, or while ready is low, accept no bit.
- R8: Done (read bit 0) rises on the edge that accepts bit number DONE_BITS. Ready falls on the same edge, so later clock edges accept no bit. Done stays set while clear is high.
- R9: One cycle after the clear line is seen low, ready, done, the captured word and the bit count are all zero. A new load then needs DONE_BITS fresh bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read value: {11'b0, 1'b0, clock, data, ready, done} |
| pin_clear_n | output | 1 | Active-low device clear line |
| pin_sclk | output | 1 | Serial configuration clock line |
| pin_sdata | output | 1 | Serial configuration data line |
| captured | output | SHIFT_W | Last SHIFT_W bits the device model accepted |

## Verification
On every cycle, the assertions check the following:
- The lines follow writes and hold between them.
- A detected clock rise never lasts two cycles.
- Ready rises only after clear has been high.
- The captured word changes only after an accepted edge.
- Done excludes ready and stays sticky.
- Clear empties the device one cycle later.

Some behaviours can only be shown by the bench's scenarios:
- The exact bit that sets done.
- The contents of the captured word after a full load.
- That edges sent before ready, while clear is low, with the clock held high, or after done leave the device unchanged.
- That a mid-load clear restarts the bit count.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int REG_W    = 16;
  // register bit positions (software visible, fixed)
  localparam int BIT_CLRN = 4;
  localparam int BIT_SCLK = 3;
  localparam int BIT_SDAT = 2;
  localparam int BIT_RDY  = 1;
  localparam int BIT_DONE = 0;

  typedef struct packed {
    logic clear_n;
    logic sclk;
    logic sdata;
  } cfg_pins_t;

endpackage

// File: rtl/cfgp_host_reg.sv
module cfgp_host_reg
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             dev_ready,
  input  logic             dev_done,
  output cfg_pins_t        pins,
  output logic [REG_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pins <= '0;
    end else if (wr) begin
      pins.clear_n <= wdata[BIT_CLRN];
      pins.sclk    <= wdata[BIT_SCLK];
      pins.sdata   <= wdata[BIT_SDAT];
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[BIT_SCLK] = pins.sclk;
    rdata[BIT_SDAT] = pins.sdata;
    rdata[BIT_RDY]  = dev_ready;
    rdata[BIT_DONE] = dev_done;
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-1:BIT_CLRN+1], wdata[BIT_RDY:0]};

  // R2: a write lands on the lines one edge later
  a_r2_write_to_pins: assert property (@(posedge clk) disable iff (rst)
    wr |=> (pins.clear_n == $past(wdata[BIT_CLRN])) &&
           (pins.sclk    == $past(wdata[BIT_SCLK])) &&
           (pins.sdata   == $past(wdata[BIT_SDAT])));

  // R2: without a write the lines hold
  a_r2_pins_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(pins));

endmodule

// File: rtl/cfgp_rise_det.sv
module cfgp_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R6: a level held high yields a single rise
  a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/cfgp_dev_model.sv
module cfgp_dev_model #(
  parameter int DONE_BITS = 24,
  parameter int SHIFT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_n,
  input  logic               sdata,
  input  logic               sclk_rise,
  output logic               ready,
  output logic               done,
  output logic [SHIFT_W-1:0] word
);

  localparam int CNT_W = $clog2(DONE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DONE_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic             take;
  logic             fin;

  assign take = sclk_rise & ready;
  assign fin  = take & (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || !clear_n) begin
      ready <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      word  <= '0;
    end else begin
      if (take) begin
        word <= {word[SHIFT_W-2:0], sdata};
        cnt  <= cnt + 1'b1;
      end
      done  <= done | fin;
      ready <= ~(done | fin);
    end
  end

  // R9: clear empties the device one cycle later
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> !ready && !done && (word == '0) && (cnt == '0));

  // R4: ready only rises after clear was high
  a_r4_ready_after_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(clear_n));

  // R5 / R7: captured word changes only after an accepted edge
  a_r5_word_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (clear_n && (word != $past(word)) && $past(clear_n)) |-> $past(sclk_rise && ready));

  // R8: done is sticky while clear is high, and excludes ready
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && clear_n) |=> done);
  a_r8_done_not_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> !ready);

  // R8: the counter never passes the target
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DONE_BITS));

endmodule

// File: rtl/cfg_shift_port.sv
module cfg_shift_port
  import cfgp_pkg::*;
#(
  parameter int DONE_BITS = 24,
  parameter int SHIFT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               pin_clear_n,
  output logic               pin_sclk,
  output logic               pin_sdata,
  output logic [SHIFT_W-1:0] captured
);

  cfg_pins_t pins;
  logic      dev_ready;
  logic      dev_done;
  logic      sclk_rise;

  cfgp_host_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr        (host_wr),
    .wdata     (host_wdata),
    .dev_ready (dev_ready),
    .dev_done  (dev_done),
    .pins      (pins),
    .rdata     (host_rdata)
  );

  cfgp_rise_det u_rise (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pins.sclk),
    .rise (sclk_rise)
  );

  cfgp_dev_model #(
    .DONE_BITS (DONE_BITS),
    .SHIFT_W   (SHIFT_W)
  ) u_dev (
    .clk       (clk),
    .rst       (rst),
    .clear_n   (pins.clear_n),
    .sdata     (pins.sdata),
    .sclk_rise (sclk_rise),
    .ready     (dev_ready),
    .done      (dev_done),
    .word      (captured)
  );

  assign pin_clear_n = pins.clear_n;
  assign pin_sclk    = pins.sclk;
  assign pin_sdata   = pins.sdata;

endmodule

// File: tb/cfg_shift_port_tb_top.sv
`timescale 1ns/1ps
module cfg_shift_port_tb_top;

  localparam int N = 24;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_wr = 1'b0;
  logic [15:0]  host_wdata = '0;
  logic [15:0]  host_rdata;
  logic         pin_clear_n, pin_sclk, pin_sdata;
  logic [W-1:0] captured;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  cfg_shift_port #(.DONE_BITS(N), .SHIFT_W(W)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pin_clear_n(pin_clear_n), .pin_sclk(pin_sclk),
    .pin_sdata(pin_sdata), .captured(captured)
  );

  // behavioural reference of the requirements
  bit           m_clrn, m_clk, m_dat, m_prev, m_rdy, m_done;
  int           m_cnt;
  logic [W-1:0] m_word;

  always @(posedge clk) begin
    bit acc;
    if (rst) begin
      m_clrn = 0; m_clk = 0; m_dat = 0; m_prev = 0;
      m_rdy = 0; m_done = 0; m_cnt = 0; m_word = '0;
    end else begin
      if (!m_clrn) begin
        m_rdy = 0; m_done = 0; m_cnt = 0; m_word = '0;
      end else begin
        acc = m_clk && !m_prev && m_rdy;
        if (acc) begin
          m_word = {m_word[W-2:0], m_dat};
          m_cnt++;
          if (m_cnt == N) m_done = 1;
        end
        m_rdy = !m_done;
      end
      m_prev = m_clk;
      if (host_wr) begin
        m_clrn = host_wdata[4]; m_clk = host_wdata[3]; m_dat = host_wdata[2];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the reference (R2 R3 R4 R5 R8)
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 rdata", 32'(host_rdata), 32'({11'b0, 1'b0, m_clk, m_dat, m_rdy, m_done}));
      check("R2 pins", 32'({pin_clear_n, pin_sclk, pin_sdata}), 32'({m_clrn, m_clk, m_dat}));
      check("R5 captured", 32'(captured), 32'(m_word));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(logic [15:0] v);
    @(negedge clk); host_wr = 1'b1; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    wr(16'h0010 | (16'(b) << 2));
    wr(16'h0018 | (16'(b) << 2));
  endtask

  initial begin
    logic [W-1:0] exp_word;
    logic [N-1:0] pat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", 32'(host_rdata), 32'h0);
    check("R1 clear_n", 32'(pin_clear_n), 32'h0);
    check("R1 captured", 32'(captured), 32'h0);

    // R7: edge while clear is low
    wr(16'h000C); wr(16'h0004); idle(2);
    check("R7 clear low edge", 32'(captured), 32'h0);
    check("R7 clear low ready", 32'(host_rdata[1:0]), 32'h0);
    wr(16'h0000);

    // R7: edge sent together with clear release, before ready
    wr(16'h001C);
    check("R3 readback clk/dat", 32'(host_rdata), 32'h000C);
    check("R4 ready not yet", 32'(host_rdata[1]), 32'h0);
    idle(1);
    check("R4 ready one cycle later", 32'(host_rdata[1]), 32'h1);
    check("R7 early edge ignored", 32'(captured), 32'h0);

    // R3: upper bits ignored, bit 4 reads 0
    wr(16'hFFF0);
    check("R3 upper bits zero", 32'(host_rdata & 16'hFFF0), 32'h0);
    check("R2 clear stays high", 32'(pin_clear_n), 32'h1);

    // full load
    pat = 24'hA5_3C_96;
    exp_word = '0;
    for (int i = N - 1; i >= 0; i--) begin
      send_bit(pat[i]);
      exp_word = {exp_word[W-2:0], pat[i]};
      if (i == N - 5) begin
        // R6: repeated 1 on clock accepts nothing
        idle(1);
        wr(16'h0018); wr(16'h001C); idle(1);
        check("R6 clock held high", 32'(captured), 32'(exp_word));
      end
      if (i == 1) begin
        idle(1);
        check("R8 not done early", 32'(host_rdata[0]), 32'h0);
      end
    end
    idle(1);
    check("R8 done set", 32'(host_rdata[1:0]), 32'h1);
    check("R5 captured word", 32'(captured), 32'(exp_word));

    // R8: edges after done are ignored
    send_bit(1'b1); send_bit(1'b0); idle(1);
    check("R8 after done", 32'(captured), 32'(exp_word));
    check("R8 done sticky", 32'(host_rdata[0]), 32'h1);

    // R9: clear empties, partial load then clear restarts count
    wr(16'h0000); idle(1);
    check("R9 cleared done", 32'(host_rdata[1:0]), 32'h0);
    check("R9 cleared word", 32'(captured), 32'h0);
    wr(16'h0010); idle(1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    wr(16'h0000); wr(16'h0010); idle(1);
    pat = 24'h1E_0F_71;
    exp_word = '0;
    for (int i = N - 1; i >= 0; i--) begin
      send_bit(pat[i]);
      exp_word = {exp_word[W-2:0], pat[i]};
      if (i == 5) begin
        idle(1);
        check("R9 count restarted", 32'(host_rdata[0]), 32'h0);
      end
    end
    idle(1);
    check("R9 reload done", 32'(host_rdata[1:0]), 32'h1);
    check("R9 reload word", 32'(captured), 32'(exp_word));

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule